// File: doc/BRIEF.md
# Next Fetch Address Selector

This block chooses the address of the next instruction to fetch, once per cycle, from the current 32-bit program counter. A direct-mapped table of resolved branches is looked up with the current PC. Each entry holds a valid flag, an address tag, a branch kind and a target. A small circular stack of return addresses supplies the targets for return instructions. The block does not predict branch direction itself. An external predictor's taken/not-taken bit is consulted only for conditional branches.

The back end writes resolved branches into the table through an update port. Each write replaces whatever entry sat at that PC's index. Each lookup gives a hit flag, the kind of the entry found, a taken flag and the chosen next PC. When there is no hit, or a return finds an empty stack, the chosen next PC is the sequential address PC+4.

Top module: `npc_unit`

## Requirements
- R1: After reset every table entry is invalid and the return stack is empty, so any lookup gives hit=0, taken=0 and next_pc = fetch_pc+4.
- R2: The table index is fetch_pc[11:2] and the tag is fetch_pc[31:12]. A lookup whose index entry is invalid or carries a different tag is a miss: hit=0, taken=0, next_pc = fetch_pc+4.
- R3: A hit on kind 0 (jump) or kind 2 (call) is always taken, and next_pc is the stored target.
- R4: A hit on kind 1 (conditional) follows dir_taken: when it is 1, next_pc is the stored target and taken=1; when it is 0, next_pc is fetch_pc+4 and taken=0.
- R5: A hit on a call with fetch_valid=1 pushes fetch_pc+4 onto the return stack.
- R6: A hit on kind 3 (return) with a non-empty stack is taken. Its next_pc is the top of the stack, which is popped when fetch_valid=1, so nested calls return in last-in first-out order.
- R7: A return hit with an empty stack gives taken=0 and next_pc = fetch_pc+4, and it leaves the stack unchanged.
- R8: The stack holds 8 addresses. A push onto a full stack overwrites the oldest entry, so after 9 pushes the 8 newest come back in reverse order, and the next return finds the stack empty.
- R9: An update with upd_valid=1 writes the kind, tag and target at upd_pc's index and replaces any older entry there. A lookup in the same cycle still sees the old contents, and the new entry is visible from the next cycle.
- R10: With fetch_valid=0 the outputs are still produced, but the return stack neither pushes nor pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Lookup is a real fetch; allows stack push and pop |
| fetch_pc | input | 32 | Current fetch address |
| dir_taken | input | 1 | Direction guess for conditional branches |
| upd_valid | input | 1 | Write a resolved branch into the table |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_kind | input | 2 | 0 jump, 1 conditional, 2 call, 3 return |
| upd_target | input | 32 | Resolved target address |
| pred_hit | output | 1 | Valid entry with matching tag found |
| pred_kind | output | 2 | Kind of the matching entry (0 on a miss) |
| pred_taken | output | 1 | Next PC is a redirect rather than sequential |
| next_pc | output | 32 | Chosen next fetch address |

## Verification
Corruption in the table shows up on the very lookup that reads the damaged index. A wrong tag or a stuck valid bit turns a redirect into a sequential address, or the reverse. A wrong stack pointer or a wrong count stays hidden until a later return. That return then yields an address from the wrong depth, or falls back to PC+4 too early or too late. Each fetch is therefore compared with a reference model of a table and a bounded queue. Call and return chains are run deep enough to wrap the stack, so that such errors reach the ports within a few cycles.

// File: rtl/npc_unit.sv
module npc_unit #(
  parameter int PC_W      = 32,
  parameter int IDX_W     = 10,
  parameter int RAS_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            dir_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [1:0]      upd_kind,
  input  logic [PC_W-1:0] upd_target,
  output logic            pred_hit,
  output logic [1:0]      pred_kind,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc
);
  localparam int TAG_W   = PC_W - IDX_W - 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SP_W    = (RAS_DEPTH > 1) ? $clog2(RAS_DEPTH) : 1;
  localparam int CNT_W   = $clog2(RAS_DEPTH + 1);
  localparam logic [1:0] K_JMP = 2'd0, K_BR = 2'd1, K_CALL = 2'd2, K_RET = 2'd3;

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_m  [ENTRIES];
  logic [1:0]         kind_m [ENTRIES];
  logic [PC_W-1:0]    tgt_m  [ENTRIES];

  logic [PC_W-1:0]    stk [RAS_DEPTH];
  logic [SP_W-1:0]    sp;
  logic [CNT_W-1:0]   cnt;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag;
  logic [PC_W-1:0]  seq_pc;
  logic             stk_has, do_push, do_pop;
  logic [SP_W-1:0]  sp_up, sp_dn;
  logic             unused_upd_lsb;

  assign f_idx   = fetch_pc[IDX_W+1:2];
  assign f_tag   = fetch_pc[PC_W-1:IDX_W+2];
  assign u_idx   = upd_pc[IDX_W+1:2];
  assign seq_pc  = fetch_pc + PC_W'(4);
  assign stk_has = (cnt != '0);
  assign unused_upd_lsb = ^upd_pc[1:0];

  assign pred_hit  = vld[f_idx] && (tag_m[f_idx] == f_tag);
  assign pred_kind = pred_hit ? kind_m[f_idx] : K_JMP;

  always_comb begin
    pred_taken = 1'b0;
    next_pc    = seq_pc;
    if (pred_hit) begin
      unique case (pred_kind)
        K_JMP, K_CALL: begin
          pred_taken = 1'b1;
          next_pc    = tgt_m[f_idx];
        end
        K_BR: if (dir_taken) begin
          pred_taken = 1'b1;
          next_pc    = tgt_m[f_idx];
        end
        K_RET: if (stk_has) begin
          pred_taken = 1'b1;
          next_pc    = stk[sp];
        end
        default: ;
      endcase
    end
  end

  assign do_push = fetch_valid && pred_hit && (pred_kind == K_CALL);
  assign do_pop  = fetch_valid && pred_hit && (pred_kind == K_RET) && stk_has;
  assign sp_up   = (sp == SP_W'(RAS_DEPTH - 1)) ? '0 : sp + SP_W'(1);
  assign sp_dn   = (sp == '0) ? SP_W'(RAS_DEPTH - 1) : sp - SP_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (upd_valid) vld[u_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (upd_valid) begin
      tag_m[u_idx]  <= upd_pc[PC_W-1:IDX_W+2];
      kind_m[u_idx] <= upd_kind;
      tgt_m[u_idx]  <= upd_target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= SP_W'(RAS_DEPTH - 1);
      cnt <= '0;
    end else if (do_push) begin
      sp  <= sp_up;
      if (cnt != CNT_W'(RAS_DEPTH)) cnt <= cnt + CNT_W'(1);
    end else if (do_pop) begin
      sp  <= sp_dn;
      cnt <= cnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) stk[sp_up] <= seq_pc;
  end
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int PC_W      = 32,
  parameter int RAS_DEPTH = 8,
  parameter int CNT_W     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            dir_taken,
  input logic            pred_hit,
  input logic [1:0]      pred_kind,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic [CNT_W-1:0] cnt
);
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> (cnt == '0));

  a_r2_miss_seq: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (!pred_taken && next_pc == fetch_pc + PC_W'(4)));

  a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && (pred_kind == 2'd0 || pred_kind == 2'd2)) |-> pred_taken);

  a_r4_cond_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && pred_kind == 2'd1) |-> (pred_taken == dir_taken));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && pred_hit && pred_kind == 2'd3 && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r7_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && pred_kind == 2'd3 && cnt == '0) |-> (!pred_taken && next_pc == fetch_pc + PC_W'(4)));

  a_r8_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(RAS_DEPTH));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(cnt));
endmodule

bind npc_unit npc_unit_chk #(.PC_W(PC_W), .RAS_DEPTH(RAS_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .dir_taken(dir_taken), .pred_hit(pred_hit), .pred_kind(pred_kind),
  .pred_taken(pred_taken), .next_pc(next_pc), .cnt(cnt)
);

// File: tb/sim_npc_unit.sv
`timescale 1ns/1ps
module sim_npc_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_valid = 1'b0, dir_taken = 1'b0, upd_valid = 1'b0;
  logic [31:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic [1:0] upd_kind = '0;
  logic pred_hit, pred_taken;
  logic [1:0] pred_kind;
  logic [31:0] next_pc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  npc_unit u0 (.clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .dir_taken(dir_taken), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_kind(upd_kind),
    .upd_target(upd_target), .pred_hit(pred_hit), .pred_kind(pred_kind),
    .pred_taken(pred_taken), .next_pc(next_pc));

  bit          m_v [int];
  logic [19:0] m_tag [int];
  logic [1:0]  m_k [int];
  logic [31:0] m_t [int];
  logic [31:0] m_stk [$];

  task automatic step(input bit fv, input logic [31:0] pc, input bit dt,
                      input bit uv, input logic [31:0] upc, input logic [1:0] uk,
                      input logic [31:0] ut, input string req);
    int idx;
    bit e_hit, e_tk;
    logic [1:0] e_k;
    logic [31:0] e_pc;
    fetch_valid = fv; fetch_pc = pc; dir_taken = dt;
    upd_valid = uv; upd_pc = upc; upd_kind = uk; upd_target = ut;
    #1;
    idx = int'(pc[11:2]);
    e_hit = m_v.exists(idx) && m_tag[idx] == pc[31:12];
    e_k = e_hit ? m_k[idx] : 2'd0;
    e_tk = 0; e_pc = pc + 32'd4;
    if (e_hit) begin
      if (e_k == 2'd0 || e_k == 2'd2 || (e_k == 2'd1 && dt)) begin e_tk = 1; e_pc = m_t[idx]; end
      else if (e_k == 2'd3 && m_stk.size() > 0) begin e_tk = 1; e_pc = m_stk[$]; end
    end
    checks++;
    if (pred_hit !== e_hit || pred_kind !== e_k || pred_taken !== e_tk || next_pc !== e_pc) begin
      fails++;
      $display("FAIL %s pc=%h actual hit=%0b kind=%0d taken=%0b next=%h expected hit=%0b kind=%0d taken=%0b next=%h",
               req, pc, pred_hit, pred_kind, pred_taken, next_pc, e_hit, e_k, e_tk, e_pc);
    end
    @(posedge clk);
    if (fv && e_hit && e_k == 2'd2) begin
      m_stk.push_back(pc + 32'd4);
      if (m_stk.size() > 8) void'(m_stk.pop_front());
    end else if (fv && e_hit && e_k == 2'd3 && m_stk.size() > 0) void'(m_stk.pop_back());
    if (uv) begin
      idx = int'(upc[11:2]);
      m_v[idx] = 1; m_tag[idx] = upc[31:12]; m_k[idx] = uk; m_t[idx] = ut;
    end
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input bit dt, input string req);
    step(1, pc, dt, 0, '0, 2'd0, '0, req);
  endtask

  task automatic wr(input logic [31:0] pc, input logic [1:0] k, input logic [31:0] t);
    step(0, 32'h0000_0F00, 0, 1, pc, k, t, "R9 write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    look(32'h0000_0100, 0, "R1 reset miss");
    look(32'h0000_2000, 1, "R1 reset miss");
    step(1, 32'h0000_1000, 0, 1, 32'h0000_1000, 2'd0, 32'h0000_4000, "R9 same-cycle old");
    look(32'h0000_1000, 0, "R3 jump taken");
    look(32'h0000_2000, 0, "R2 alias tag miss");
    wr(32'h0000_1010, 2'd1, 32'h0000_1100);
    look(32'h0000_1010, 1, "R4 cond taken");
    look(32'h0000_1010, 0, "R4 cond not taken");
    wr(32'h0000_3000, 2'd3, 32'h0);
    look(32'h0000_3000, 0, "R7 empty return");
    wr(32'h0000_1020, 2'd2, 32'h0000_5000);
    look(32'h0000_1020, 0, "R5 call push");
    look(32'h0000_3000, 0, "R6 return pops");
    look(32'h0000_3000, 0, "R7 empty after pop");
    step(0, 32'h0000_1020, 0, 0, '0, 2'd0, '0, "R10 idle call");
    look(32'h0000_3000, 0, "R10 no push seen");
    look(32'h0000_1020, 0, "R5 nested call 1");
    wr(32'h0000_1024, 2'd2, 32'h0000_6000);
    look(32'h0000_1024, 0, "R5 nested call 2");
    step(0, 32'h0000_3000, 0, 0, '0, 2'd0, '0, "R10 idle return");
    look(32'h0000_3000, 0, "R6 inner return");
    look(32'h0000_3000, 0, "R6 outer return");
    for (int i = 0; i < 9; i++) wr(32'h0000_1200 + i * 4, 2'd2, 32'h0000_7000 + i * 16);
    for (int i = 0; i < 9; i++) look(32'h0000_1200 + i * 4, 0, "R8 fill");
    for (int i = 0; i < 9; i++) look(32'h0000_3000, 0, "R8 drain");
    step(1, 32'h0000_1010, 0, 1, 32'h0000_1010, 2'd0, 32'h0000_4444, "R9 same-cycle old");
    look(32'h0000_1010, 0, "R9 replaced");
    wr(32'h0004_1010, 2'd1, 32'h0000_8888);
    look(32'h0000_1010, 0, "R2 evicted tag miss");
    look(32'h0004_1010, 1, "R9 new tag hit");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog all requirements actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule